// File: doc/BRIEF.md
# Interrupt Enable Latch Pair

This unit sits beside the instruction decoder of a small 8-bit processor and owns the two interrupt enable latches. The primary latch gates acceptance of maskable interrupts. The shadow latch keeps a copy that survives a non-maskable interrupt entry. The decoder and the interrupt controller send one-cycle strobes for these events:
- enable and disable instructions
- non-maskable entry and return
- acceptance of a maskable interrupt
- the two phases (start and flag write) of an instruction that moves the interrupt-vector or refresh register into the accumulator

The unit answers with the latch states, a permission to accept a maskable interrupt, and the parity/overflow flag bit that the register move leaves behind.

That flag bit should report whether interrupts were enabled. One question decides it: does an interrupt accepted while the register move is in flight clear the shadow latch before it is sampled, or after? The parameter `LEGACY_ORDER` picks the behaviour. With 1, the acceptance lands first and the flag reads 0, even though interrupts were on. With 0, the shadow latch is captured when the instruction starts, and the flag tells the truth. In both settings a flag of 1 means interrupts were enabled.

After an enable instruction, acceptance stays blocked until the following instruction has finished. A return from an interrupt handler can therefore execute before the next interrupt is taken.

Top module: `irq_enable_unit`

## Requirements
- R1: While reset is asserted, and after it is released, both latches, the enable block, the permission output and the flag output are 0.
- R2: An enable strobe that takes effect sets both latches to 1 in the next cycle.
- R3: A disable strobe that takes effect clears both latches in the next cycle and ends any pending enable block.
- R4: An accepted maskable interrupt clears both latches in the next cycle.
- R5: A non-maskable entry clears the primary latch and leaves the shadow latch unchanged.
- R6: A non-maskable return copies the shadow latch into the primary latch; the shadow latch is unchanged.
- R7: When several strobes arrive in one cycle, only one acts. Priority from highest to lowest is: non-maskable entry, maskable accept, disable, enable, non-maskable return. With no strobe, both latches hold.
- R8: `int_allow_o` equals primary latch AND NOT enable-block. An enable that takes effect sets the block. An instruction-done pulse in that same cycle is ignored. The next instruction-done pulse clears the block.
- R9: `pv_flag_o` changes only in the cycle after a flag-write strobe and holds its value otherwise.
- R10: With `LEGACY_ORDER`=0, the flag written equals the shadow latch as it was in the start cycle of the read, whatever interrupt is accepted up to and including the write cycle.
- R11: With `LEGACY_ORDER`=1, the flag written equals the shadow latch at the write cycle after that cycle's maskable accept has been applied. An accept in or before the write cycle therefore yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ei_stb_i | input | 1 | Enable instruction strobe |
| di_stb_i | input | 1 | Disable instruction strobe |
| nmi_entry_i | input | 1 | Non-maskable interrupt entry |
| nmi_return_i | input | 1 | Return from non-maskable handler |
| int_ack_i | input | 1 | Maskable interrupt accepted |
| ir_rd_start_i | input | 1 | First cycle of the vector/refresh register read |
| ir_rd_copy_i | input | 1 | Flag write cycle of that read (may equal start cycle) |
| insn_done_i | input | 1 | Last cycle of an instruction |
| iff1_o | output | 1 | Primary enable latch |
| iff2_o | output | 1 | Shadow enable latch |
| int_allow_o | output | 1 | Maskable interrupt may be accepted |
| pv_flag_o | output | 1 | Parity/overflow bit from the register read |

## Verification
Every latch and the enable block reach the ports one cycle after a strobe. A wrong priority or a lost update therefore shows on `iff1_o`, `iff2_o` or `int_allow_o` on the very next edge. A stale or badly ordered shadow-latch sample shows only on `pv_flag_o`, one cycle after the write strobe, so the bench places accepts between and on the read phases. Both orderings are instantiated side by side under the same stimulus, so a swapped variant differs from its model at the first read that overlaps an accept.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;

  typedef enum logic [2:0] {
    IFF_HOLD = 3'd0,
    IFF_NMI  = 3'd1,
    IFF_ACK  = 3'd2,
    IFF_DI   = 3'd3,
    IFF_EI   = 3'd4,
    IFF_RETN = 3'd5
  } iff_op_e;

  // Fixed priority: entry, accept, disable, enable, return.
  function automatic iff_op_e pick_iff_op(input logic nmi, input logic ack,
                                          input logic di, input logic ei,
                                          input logic retn);
    iff_op_e op;
    if (nmi)       op = IFF_NMI;
    else if (ack)  op = IFF_ACK;
    else if (di)   op = IFF_DI;
    else if (ei)   op = IFF_EI;
    else if (retn) op = IFF_RETN;
    else           op = IFF_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/iff_latch_pair.sv
module iff_latch_pair
  import irq_en_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  iff_op_e op_i,
  output logic    iff1_o,
  output logic    iff2_o
);

  logic iff1_q, iff1_d;
  logic iff2_q, iff2_d;
  logic upd_en;

  assign upd_en = (op_i != IFF_HOLD);

  always_comb begin
    iff1_d = iff1_q;
    iff2_d = iff2_q;
    unique case (op_i)
      IFF_NMI:  iff1_d = 1'b0;
      IFF_ACK:  begin iff1_d = 1'b0; iff2_d = 1'b0; end
      IFF_DI:   begin iff1_d = 1'b0; iff2_d = 1'b0; end
      IFF_EI:   begin iff1_d = 1'b1; iff2_d = 1'b1; end
      IFF_RETN: iff1_d = iff2_q;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
    end else if (upd_en) begin
      iff1_q <= iff1_d;
      iff2_q <= iff2_d;
    end
  end

  assign iff1_o = iff1_q;
  assign iff2_o = iff2_q;

  a_r2_ei_sets: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == IFF_EI |=> iff1_o && iff2_o);
  a_r3_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == IFF_DI |=> !iff1_o && !iff2_o);
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == IFF_ACK |=> !iff1_o && !iff2_o);
  a_r5_nmi_keeps_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == IFF_NMI |=> !iff1_o && (iff2_o == $past(iff2_o)));
  a_r6_retn_restores: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == IFF_RETN |=> (iff1_o == $past(iff2_o)) && $stable(iff2_o));
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == IFF_HOLD |=> $stable(iff1_o) && $stable(iff2_o));

endmodule

// File: rtl/ei_hold.sv
module ei_hold
  import irq_en_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  iff_op_e op_i,
  input  logic    insn_done_i,
  output logic    blk_o
);

  logic blk_q, blk_d;
  logic blk_en;

  assign blk_en = (op_i == IFF_EI) || (op_i == IFF_DI) || insn_done_i;

  always_comb begin
    if (op_i == IFF_EI)      blk_d = 1'b1;
    else                     blk_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_q <= 1'b0;
    else if (blk_en) blk_q <= blk_d;
  end

  assign blk_o = blk_q;

  a_r8_ei_blocks_next: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == IFF_EI |=> blk_o);
  a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != IFF_EI) && insn_done_i |=> !blk_o);

endmodule

// File: rtl/pv_sampler.sv
module pv_sampler #(
  parameter bit LEGACY_ORDER = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic copy_i,
  input  logic ack_applied_i,
  input  logic iff2_q_i,
  output logic pv_o
);

  logic pv_q, pv_d;
  logic src;

  generate
    if (LEGACY_ORDER) begin : g_legacy
      // Acceptance clears the shadow latch ahead of the flag write.
      assign src = iff2_q_i & ~ack_applied_i;
    end else begin : g_fixed
      logic snap_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap_q <= 1'b0;
        else if (start_i) snap_q <= iff2_q_i;
      end
      assign src = start_i ? iff2_q_i : snap_q;

      a_r10_fixed_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        copy_i && start_i |=> pv_o == $past(iff2_q_i));
    end
  endgenerate

  always_comb pv_d = src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pv_q <= 1'b0;
    else if (copy_i) pv_q <= pv_d;
  end

  assign pv_o = pv_q;

  a_r9_pv_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_i |=> $stable(pv_o));
  a_r11_one_means_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    copy_i && start_i && !iff2_q_i |=> !pv_o);

  generate
    if (LEGACY_ORDER) begin : g_leg_chk
      a_r11_legacy_ack_zero: assert property (@(posedge clk) disable iff (!rst_n)
        copy_i && ack_applied_i |=> !pv_o);
    end
  endgenerate

endmodule

// File: rtl/irq_enable_unit.sv
module irq_enable_unit
  import irq_en_pkg::*;
#(
  parameter bit LEGACY_ORDER = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ei_stb_i,
  input  logic di_stb_i,
  input  logic nmi_entry_i,
  input  logic nmi_return_i,
  input  logic int_ack_i,
  input  logic ir_rd_start_i,
  input  logic ir_rd_copy_i,
  input  logic insn_done_i,
  output logic iff1_o,
  output logic iff2_o,
  output logic int_allow_o,
  output logic pv_flag_o
);

  iff_op_e op;
  logic    iff1, iff2, blk;

  always_comb op = pick_iff_op(nmi_entry_i, int_ack_i, di_stb_i, ei_stb_i, nmi_return_i);

  iff_latch_pair u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op),
    .iff1_o (iff1),
    .iff2_o (iff2)
  );

  ei_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op),
    .insn_done_i (insn_done_i),
    .blk_o       (blk)
  );

  pv_sampler #(.LEGACY_ORDER(LEGACY_ORDER)) u_pv (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (ir_rd_start_i),
    .copy_i        (ir_rd_copy_i),
    .ack_applied_i (op == IFF_ACK),
    .iff2_q_i      (iff2),
    .pv_o          (pv_flag_o)
  );

  assign iff1_o      = iff1;
  assign iff2_o      = iff2;
  assign int_allow_o = iff1 & ~blk;

  a_r8_allow_needs_iff1: assert property (@(posedge clk) disable iff (!rst_n)
    int_allow_o |-> iff1_o);
  a_r8_no_allow_after_ei: assert property (@(posedge clk) disable iff (!rst_n)
    ei_stb_i && !nmi_entry_i && !int_ack_i && !di_stb_i |=> !int_allow_o);
  a_r7_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_entry_i |=> !iff1_o && $stable(iff2_o));

endmodule

// File: tb/irq_enable_unit_tb_top.sv
module irq_enable_unit_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ei, di, nmi, retn, ack, rd_start, rd_copy, done;
  logic f_iff1, f_iff2, f_allow, f_pv;
  logic l_iff1, l_iff2, l_allow, l_pv;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench model state
  bit m_iff1, m_iff2, m_blk, m_pvf, m_pvl, m_snap;
  string m_tag;
  bit m_copied;

  always #2ns clk = ~clk;

  irq_enable_unit #(.LEGACY_ORDER(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .ei_stb_i(ei), .di_stb_i(di),
    .nmi_entry_i(nmi), .nmi_return_i(retn), .int_ack_i(ack),
    .ir_rd_start_i(rd_start), .ir_rd_copy_i(rd_copy), .insn_done_i(done),
    .iff1_o(f_iff1), .iff2_o(f_iff2), .int_allow_o(f_allow), .pv_flag_o(f_pv));

  irq_enable_unit #(.LEGACY_ORDER(1'b1)) dut_leg_i (
    .clk(clk), .rst_n(rst_n), .ei_stb_i(ei), .di_stb_i(di),
    .nmi_entry_i(nmi), .nmi_return_i(retn), .int_ack_i(ack),
    .ir_rd_start_i(rd_start), .ir_rd_copy_i(rd_copy), .insn_done_i(done),
    .iff1_o(l_iff1), .iff2_o(l_iff2), .int_allow_o(l_allow), .pv_flag_o(l_pv));

  // 0 hold, 1 nmi, 2 ack, 3 di, 4 ei, 5 retn (priority order of R7)
  function automatic int op_of(bit n, bit a, bit d, bit e, bit r);
    if (n) return 1;
    if (a) return 2;
    if (d) return 3;
    if (e) return 4;
    if (r) return 5;
    return 0;
  endfunction

  function automatic string tag_of(int op, int nstb);
    if (nstb > 1) return "R7";
    case (op)
      1: return "R5";
      2: return "R4";
      3: return "R3";
      4: return "R2";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic bit legacy_pv(bit iff2, int op);
    return iff2 & (op != 2);
  endfunction

  function automatic bit fixed_pv(bit iff2, bit start, bit snap);
    return start ? iff2 : snap;
  endfunction

  task automatic chk(string req, string what, bit got, bit exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic step_model();
    int op;
    int nstb;
    bit o1, o2;
    op = op_of(nmi, ack, di, ei, retn);
    nstb = int'(nmi) + int'(ack) + int'(di) + int'(ei) + int'(retn);
    o1 = m_iff1; o2 = m_iff2;
    m_copied = rd_copy;
    if (rd_copy) begin
      m_pvl = legacy_pv(o2, op);
      m_pvf = fixed_pv(o2, rd_start, m_snap);
    end
    if (rd_start) m_snap = o2;
    case (op)
      1: m_iff1 = 1'b0;
      2: begin m_iff1 = 1'b0; m_iff2 = 1'b0; end
      3: begin m_iff1 = 1'b0; m_iff2 = 1'b0; end
      4: begin m_iff1 = 1'b1; m_iff2 = 1'b1; end
      5: m_iff1 = o2;
      default: ;
    endcase
    if (op == 4) m_blk = 1'b1;
    else if (op == 3 || done) m_blk = 1'b0;
    m_tag = tag_of(op, nstb);
  endtask

  task automatic check_all();
    chk(m_tag, "iff1 fixed", f_iff1, m_iff1);
    chk(m_tag, "iff2 fixed", f_iff2, m_iff2);
    chk(m_tag, "iff1 legacy", l_iff1, m_iff1);
    chk(m_tag, "iff2 legacy", l_iff2, m_iff2);
    chk("R8", "allow", f_allow, m_iff1 & ~m_blk);
    chk("R8", "allow legacy", l_allow, m_iff1 & ~m_blk);
    chk(m_copied ? "R10" : "R9", "pv fixed", f_pv, m_pvf);
    chk(m_copied ? "R11" : "R9", "pv legacy", l_pv, m_pvl);
  endtask

  task automatic clr_in();
    ei = 0; di = 0; nmi = 0; retn = 0; ack = 0;
    rd_start = 0; rd_copy = 0; done = 0;
  endtask

  // one cycle: inputs already set at negedge; advance and check
  task automatic cyc();
    step_model();
    @(negedge clk);
    check_all();
    clr_in();
  endtask

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int rd_left;
    bit in_rd;
    void'($urandom(32'd1234));
    clr_in();
    m_iff1 = 0; m_iff2 = 0; m_blk = 0; m_pvf = 0; m_pvl = 0; m_snap = 0;
    m_tag = "R1"; m_copied = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "iff1 in reset", f_iff1, 1'b0);
    chk("R1", "pv in reset", l_pv, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R8: EI with insn_done in same cycle stays blocked; next done releases
    ei = 1; done = 1; cyc();
    chk("R8", "blocked after EI", f_allow, 1'b0);
    cyc();
    chk("R8", "still blocked w/o done", f_allow, 1'b0);
    done = 1; cyc();
    chk("R8", "allowed after next insn", f_allow, 1'b1);

    // R10/R11: read overlapped by accept between start and copy
    rd_start = 1; cyc();
    ack = 1; cyc();
    rd_copy = 1; cyc();
    chk("R10", "fixed reports enabled", f_pv, 1'b1);
    chk("R11", "legacy reports 0", l_pv, 1'b0);

    // R11: accept in the copy cycle itself
    ei = 1; cyc();
    done = 1; cyc();
    done = 1; cyc();
    rd_start = 1; rd_copy = 1; ack = 1; cyc();
    chk("R11", "legacy same-cycle ack", l_pv, 1'b0);
    chk("R10", "fixed same-cycle ack", f_pv, 1'b1);

    // R5/R6: NMI entry then return
    ei = 1; cyc();
    nmi = 1; cyc();
    chk("R5", "iff2 kept", f_iff2, 1'b1);
    retn = 1; cyc();
    chk("R6", "iff1 restored", f_iff1, 1'b1);

    // R7: all strobes at once -> NMI wins
    nmi = 1; ack = 1; di = 1; ei = 1; retn = 1; cyc();
    chk("R7", "nmi priority iff2", f_iff2, 1'b1);

    // R3: DI ends pending block
    ei = 1; cyc();
    di = 1; cyc();
    chk("R3", "both cleared", f_iff1 | f_iff2, 1'b0);

    // random phase
    in_rd = 0; rd_left = 0;
    for (int i = 0; i < 4000; i++) begin
      nmi  = ($urandom_range(0, 29) == 0);
      ack  = m_iff1 & ~m_blk & ($urandom_range(0, 5) == 0);
      di   = ($urandom_range(0, 11) == 0);
      ei   = ($urandom_range(0, 5) == 0);
      retn = ($urandom_range(0, 9) == 0);
      done = ($urandom_range(0, 2) == 0);
      if (!in_rd && $urandom_range(0, 4) == 0) begin
        rd_start = 1; in_rd = 1; rd_left = $urandom_range(0, 2);
      end
      if (in_rd) begin
        if (rd_left == 0) begin rd_copy = 1; in_rd = 0; end
        else rd_left--;
      end
      cyc();
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule